// File: doc/BRIEF.md
# Load/Store Class Decoder and Data Extender

This unit sits between the instruction decode stage and the memory port of a 64-bit core. From the two-bit access size field and the two-bit operation field of a load/store encoding, it selects one of three operation classes: store, load or prefetch. Alongside the class it produces the signedness, the destination register width, the access width in bits, a tag-check flag and an undefined-encoding flag.

In the same registered step the unit prepares the data for the selected class. For a load it takes the raw, right-aligned word returned by memory and extends it to the register width. For a store it trims the source register to the access width and builds the byte-enable mask inside an 8-byte lane. For a prefetch it forwards the 5-bit register-number field as the hint operand. All outputs appear one clock after the request. The memory system and the register file are outside this unit.

Top module: `ls_access_unit`

## Requirements
- R1: One cycle after a valid request, exactly one strobe or none is high. When op[1]=0, op[0]=1 gives `out_load` and op[0]=0 gives `out_store`. When op[1]=1 and size=3, the class is prefetch. When op[1]=1 and size is not 3, the class is a signed load.
- R2: The encodings op=3 with size=2 and op=3 with size=3 raise `out_undef`. In that cycle `out_load`, `out_store` and `out_prefetch` are all low.
- R3: `out_wide` (1 = 64-bit register, 0 = 32-bit register) equals (size==3) when op[1]=0. For signed loads, `out_wide` is 0 when op[0]=1 and 1 when op[0]=0.
- R4: `out_signed` is high only when op[1]=1 and size is not 3.
- R5: `out_bits` equals 8 shifted left by size, giving 8, 16, 32 or 64.
- R6: `out_tag_chk` is high for every valid request whose class is not prefetch, undefined ones included. It is low for the prefetch class.
- R7: On a load strobe, `out_rdata` is the low `out_bits` bits of `in_load_raw`, sign-extended when signed and zero-extended otherwise. When `out_wide`=0, bits 63:32 are zero. Without a load strobe, `out_rdata` is zero.
- R8: On a store strobe, `out_wdata` is the low `out_bits` bits of `in_store_src` with zeros above. `out_byte_en` is a run of 2^size ones shifted left by `in_addr_lo` and cut to 8 bits. Without a store strobe, both are zero.
- R9: On a prefetch strobe, `out_hint` equals `in_rt`. Otherwise it is zero.
- R10: Every output is registered. `out_valid` follows `in_valid` by one cycle. A cycle with `in_valid` low, or with reset high, yields all strobes and flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_size | input | 2 | Access size field |
| in_op | input | 2 | Operation field |
| in_rt | input | 5 | Register-number field, used as the prefetch hint |
| in_addr_lo | input | 3 | Low address bits within the 8-byte lane |
| in_store_src | input | 64 | Store source register value |
| in_load_raw | input | 64 | Right-aligned raw load data from memory |
| out_valid | output | 1 | Result present |
| out_load | output | 1 | Load strobe |
| out_store | output | 1 | Store strobe |
| out_prefetch | output | 1 | Prefetch strobe |
| out_undef | output | 1 | Undefined encoding |
| out_signed | output | 1 | Sign-extending operation |
| out_wide | output | 1 | Register width is 64 bits (0: 32 bits) |
| out_bits | output | 7 | Access width in bits |
| out_tag_chk | output | 1 | Access is tag-checked |
| out_hint | output | 5 | Prefetch hint |
| out_wdata | output | 64 | Trimmed store data |
| out_byte_en | output | 8 | Store byte enables |
| out_rdata | output | 64 | Extended load result |

## Verification
Sign extension and upper-half clearing act together in one cycle whenever a signed load targets a 32-bit register. The undefined check and the prefetch class also meet in one cycle when size=3 and op=3. The sweep crosses every size and operation code with every lane offset and with raw words whose sign bits are set at every access width. Each outcome is compared with values the bench computes arithmetically, so a narrow signed load must show ones up to bit 31 and zeros above it, and the undefined prefetch must show no strobe while its tag flag stays low.

// File: rtl/ls_access_pkg.sv
package ls_access_pkg;

    localparam int DATA_W     = 64;
    localparam int LANE_BYTES = DATA_W / 8;
    localparam int OFS_W      = $clog2(LANE_BYTES);
    localparam int SIZE_W     = 2;
    localparam int NUM_SIZES  = 1 << SIZE_W;
    localparam int OP_W       = 2;
    localparam int HINT_W     = 5;
    localparam int NBITS_W    = $clog2(DATA_W) + 1;
    localparam int HALF_W     = DATA_W / 2;

    typedef enum logic [1:0] {
        CLS_STORE    = 2'd0,
        CLS_LOAD     = 2'd1,
        CLS_PREFETCH = 2'd2
    } ls_class_e;

    typedef struct packed {
        ls_class_e            cls;
        logic                 undef;
        logic                 sext;
        logic                 wide;
        logic [NBITS_W-1:0]   nbits;
        logic                 tag_chk;
    } ls_decode_t;

    // Mask covering the low (8 << size) bits of a data word
    function automatic logic [DATA_W-1:0] size_mask(input logic [SIZE_W-1:0] size);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_W; b++) begin
            if (b < (8 << size)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ls_class_decode.sv
module ls_class_decode
    import ls_access_pkg::*;
(
    input  logic [SIZE_W-1:0] size,
    input  logic [OP_W-1:0]   op,
    output ls_decode_t        dec
);
    localparam logic [SIZE_W-1:0] SIZE_MAX = '1;
    localparam logic [SIZE_W-1:0] SIZE_WORD = SIZE_MAX - 1'b1;

    always_comb begin
        dec         = '0;
        dec.nbits   = NBITS_W'(8) << size;
        if (!op[1]) begin
            dec.cls  = op[0] ? CLS_LOAD : CLS_STORE;
            dec.wide = (size == SIZE_MAX);
            dec.sext = 1'b0;
        end else if (size == SIZE_MAX) begin
            dec.cls   = CLS_PREFETCH;
            dec.wide  = 1'b1;
            dec.undef = op[0];
        end else begin
            dec.cls   = CLS_LOAD;
            dec.sext  = 1'b1;
            dec.wide  = !op[0];
            dec.undef = (size == SIZE_WORD) && op[0];
        end
        dec.tag_chk = (dec.cls != CLS_PREFETCH);
    end
endmodule

// File: rtl/ls_load_extend.sv
module ls_load_extend
    import ls_access_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic [SIZE_W-1:0] size,
    input  logic              sext,
    input  logic              wide,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] ext [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
        localparam int NB = 8 << g;
        if (NB >= DATA_W) begin : g_full
            assign ext[g] = raw;
        end else begin : g_part
            assign ext[g] = {{(DATA_W-NB){sext & raw[NB-1]}}, raw[NB-1:0]};
        end
    end

    always_comb begin
        value = ext[size];
        if (!wide) value[DATA_W-1:HALF_W] = '0;
    end
endmodule

// File: rtl/ls_store_pack.sv
module ls_store_pack
    import ls_access_pkg::*;
(
    input  logic [DATA_W-1:0]     src,
    input  logic [SIZE_W-1:0]     size,
    input  logic [OFS_W-1:0]      ofs,
    output logic [DATA_W-1:0]     wdata,
    output logic [LANE_BYTES-1:0] byte_en
);
    logic [OFS_W+1:0] span_end;

    assign span_end = (OFS_W+2)'(ofs) + ((OFS_W+2)'(1) << size);
    assign wdata    = src & size_mask(size);

    for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
        assign byte_en[b] = ((OFS_W+2)'(b) >= (OFS_W+2)'(ofs)) &&
                            ((OFS_W+2)'(b) <  span_end);
    end
endmodule

// File: rtl/ls_access_unit.sv
module ls_access_unit
    import ls_access_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            in_size,
    input  logic [1:0]            in_op,
    input  logic [4:0]            in_rt,
    input  logic [2:0]            in_addr_lo,
    input  logic [63:0]           in_store_src,
    input  logic [63:0]           in_load_raw,
    output logic                  out_valid,
    output logic                  out_load,
    output logic                  out_store,
    output logic                  out_prefetch,
    output logic                  out_undef,
    output logic                  out_signed,
    output logic                  out_wide,
    output logic [6:0]            out_bits,
    output logic                  out_tag_chk,
    output logic [4:0]            out_hint,
    output logic [63:0]           out_wdata,
    output logic [7:0]            out_byte_en,
    output logic [63:0]           out_rdata
);
    ls_decode_t            dec;
    logic [DATA_W-1:0]     ld_val;
    logic [DATA_W-1:0]     st_data;
    logic [LANE_BYTES-1:0] st_be;
    logic                  ld_go, st_go, pf_go;

    ls_class_decode i_dec (
        .size (in_size),
        .op   (in_op),
        .dec  (dec)
    );

    ls_load_extend i_ext (
        .raw   (in_load_raw),
        .size  (in_size),
        .sext  (dec.sext),
        .wide  (dec.wide),
        .value (ld_val)
    );

    ls_store_pack i_pack (
        .src     (in_store_src),
        .size    (in_size),
        .ofs     (in_addr_lo),
        .wdata   (st_data),
        .byte_en (st_be)
    );

    assign ld_go = in_valid && !dec.undef && (dec.cls == CLS_LOAD);
    assign st_go = in_valid && !dec.undef && (dec.cls == CLS_STORE);
    assign pf_go = in_valid && !dec.undef && (dec.cls == CLS_PREFETCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_load     <= 1'b0;
            out_store    <= 1'b0;
            out_prefetch <= 1'b0;
            out_undef    <= 1'b0;
            out_signed   <= 1'b0;
            out_wide     <= 1'b0;
            out_bits     <= '0;
            out_tag_chk  <= 1'b0;
            out_hint     <= '0;
            out_wdata    <= '0;
            out_byte_en  <= '0;
            out_rdata    <= '0;
        end else begin
            out_valid    <= in_valid;
            out_load     <= ld_go;
            out_store    <= st_go;
            out_prefetch <= pf_go;
            out_undef    <= in_valid && dec.undef;
            out_signed   <= in_valid && dec.sext;
            out_wide     <= in_valid && dec.wide;
            out_bits     <= in_valid ? dec.nbits : '0;
            out_tag_chk  <= in_valid && dec.tag_chk;
            out_hint     <= pf_go ? in_rt : '0;
            out_wdata    <= st_go ? st_data : '0;
            out_byte_en  <= st_go ? st_be : '0;
            out_rdata    <= ld_go ? ld_val : '0;
        end
    end

    // R1
    one_class_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_load, out_store, out_prefetch}));

    // R2
    undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> !(out_load || out_store || out_prefetch));

    // R6
    prefetch_untagged_chk: assert property (@(posedge clk) disable iff (rst)
        out_prefetch |-> !out_tag_chk);

    // R7
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (out_load && !out_wide) |-> (out_rdata[63:32] == 32'd0));

    // R8
    store_be_chk: assert property (@(posedge clk) disable iff (rst)
        !out_store |-> (out_byte_en == 8'd0 && out_wdata == 64'd0));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(out_valid || out_load || out_store || out_prefetch));
endmodule

// File: tb/test_ls_access_unit.sv
`timescale 1ns/100ps
module test_ls_access_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_size, in_op;
    logic [4:0]  in_rt;
    logic [2:0]  in_addr_lo;
    logic [63:0] in_store_src, in_load_raw;
    logic        out_valid, out_load, out_store, out_prefetch, out_undef;
    logic        out_signed, out_wide, out_tag_chk;
    logic [6:0]  out_bits;
    logic [4:0]  out_hint;
    logic [63:0] out_wdata, out_rdata;
    logic [7:0]  out_byte_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ls_access_unit i_ls_access_unit (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (size=%0d op=%0d ofs=%0d)",
                     req, act, exp, in_size, in_op, in_addr_lo);
        end
    endtask

    logic [63:0] pats [3];

    initial begin
        pats[0] = 64'h0123_4567_89AB_CDEF;
        pats[1] = 64'hFEDC_BA98_7654_3210;
        pats[2] = 64'h8000_0000_8000_8080;
        rst = 1'b1; in_valid = 1'b1; in_size = 2'd0; in_op = 2'd0;
        in_rt = 5'd9; in_addr_lo = 3'd0; in_store_src = '1; in_load_raw = '1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R10 reset store", {63'd0, out_store}, 64'd0);
        chk("R10 reset byte_en", {56'd0, out_byte_en}, 64'd0);
        rst = 1'b0;
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 4; o++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int p = 0; p < 3; p++) begin
                        logic e_load, e_store, e_pf, e_undef, e_sext, e_wide;
                        logic [63:0] mask, ext, e_rdata, e_wdata;
                        logic [15:0] bem;
                        int nb;
                        in_valid = 1'b1; in_size = 2'(s); in_op = 2'(o);
                        in_addr_lo = 3'(a); in_rt = 5'(s*8 + o*2 + p + 3);
                        in_load_raw = pats[p]; in_store_src = ~pats[p];
                        @(negedge clk);
                        nb = 8 << s;
                        mask = (nb == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << nb) - 64'd1);
                        e_undef = (o == 3) && (s >= 2);
                        e_sext  = (o >= 2) && (s != 3);
                        e_pf    = (o == 2) && (s == 3);
                        e_load  = !e_undef && ((o == 1) || e_sext);
                        e_store = (o == 0);
                        e_wide  = (o < 2) ? (s == 3) : (o == 2);
                        ext = pats[p] & mask;
                        if (e_sext && pats[p][nb-1]) ext = ext | ~mask;
                        if (!e_wide) ext = ext & 64'h0000_0000_FFFF_FFFF;
                        e_rdata = e_load ? ext : 64'd0;
                        e_wdata = e_store ? (~pats[p] & mask) : 64'd0;
                        bem = 16'((1 << (1 << s)) - 1) << a;
                        chk("R10 valid", {63'd0, out_valid}, 64'd1);
                        chk("R1 load strobe", {63'd0, out_load}, {63'd0, e_load});
                        chk("R1 store strobe", {63'd0, out_store}, {63'd0, e_store});
                        chk("R1 prefetch strobe", {63'd0, out_prefetch}, {63'd0, e_pf});
                        chk("R2 undef", {63'd0, out_undef}, {63'd0, e_undef});
                        chk("R4 signed", {63'd0, out_signed}, {63'd0, e_sext});
                        if (!(o >= 2 && s == 3))
                            chk("R3 wide", {63'd0, out_wide}, {63'd0, e_wide});
                        chk("R5 bits", {57'd0, out_bits}, 64'(nb));
                        chk("R6 tag", {63'd0, out_tag_chk}, {63'd0, !(o >= 2 && s == 3)});
                        chk("R7 rdata", out_rdata, e_rdata);
                        chk("R8 wdata", out_wdata, e_wdata);
                        chk("R8 byte_en", {56'd0, out_byte_en}, e_store ? {56'd0, bem[7:0]} : 64'd0);
                        chk("R9 hint", {59'd0, out_hint}, e_pf ? {59'd0, in_rt} : 64'd0);
                    end
                end
            end
        end
        // R10 idle request yields nothing
        in_valid = 1'b0; in_op = 2'd0; in_size = 2'd3;
        @(negedge clk);
        chk("R10 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R10 idle store", {63'd0, out_store}, 64'd0);
        chk("R10 idle tag", {63'd0, out_tag_chk}, 64'd0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule